// File: doc/BRIEF.md
# Memory-Resident Register Instruction Sequencer

This block is the control engine for a small machine that has no register file: the program counter and every general register are 16-bit big-endian words in the lowest bytes of data memory. All traffic goes through the same byte-wide memory port. The register set a, b, c, d, x, y, i, j, p, q, sp and pc sits at word addresses 0x00, 0x02, and so on up to 0x16, in that order. For each instruction the sequencer does five things in order:
- reads the program counter from memory;
- fetches four instruction bytes (operation code, destination operand, first source, second source);
- stores the counter plus four back to memory;
- reads both source values through an external operand decoder;
- hands them to an external ALU and writes the result to the destination location.

A start pulse launches execution. The block runs instructions until it meets the halt code or the fire code, and then leaves its busy state. The memory port has no back-pressure. A request is accepted in the cycle it is made. Read data is returned on `mem_rdata` exactly one cycle after the read request. Because the counter is re-read from memory before every fetch, an instruction that writes the counter location redirects the next fetch.

Top module: `fes_sequencer`

## Requirements
- R1: After reset, and at any time `busy` is low, `mem_req` is low. After reset, `halted` and `fire` are also low.
- R2: One cycle after a start pulse, `busy` is high. The sequencer first reads byte 0x16 (counter high byte), then byte 0x17 (counter low byte). It then reads the four instruction bytes at counter, counter+1, counter+2 and counter+3: operation code, destination, source one, source two.
- R3: The incremented counter (counter+4) is written to 0x16 (high byte) and 0x17 (low byte) before any operand location is read.
- R4: Codes 0x00 to 0x0C are ALU operations, with `alu_op` equal to the low four bits of the code. Bench ALU encodings: 0 add, 1 subtract, 5 and, 6 or, 7 xor, 10 plus one, 11 minus one, 12 copy of source one. A word operand is read high byte at `dec_addr` and low byte at `dec_addr`+1. A word result is written the same way. `mem_we` is never high without `mem_req`.
- R5: When the decoder reports a byte location (`dec_byte` high), a source is one byte, sign-extended to 16 bits. A byte destination receives only the low 8 bits of the result, and the neighbouring byte is unchanged.
- R6: Code 0xF0 ends execution: `busy` falls, `halted` rises, and no further memory request is made.
- R7: Code 0xF1 ends execution with `fire` high and `busy` low.
- R8: Any other code (0x0D to 0xEF, 0xF2 to 0xFF) writes nothing except the counter write-back, and execution continues with the next instruction.
- R9: A result written to the counter location becomes the address of the next fetch.
- R10: Every memory access moves one byte in one cycle. The read byte is taken from `mem_rdata` in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution when not busy |
| busy | output | 1 | Executing instructions |
| halted | output | 1 | Stopped by the halt code |
| fire | output | 1 | Stopped by the fire code |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW (16) | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, one cycle after request |
| dec_operand | output | 8 | Operand code to the external decoder |
| dec_addr | input | AW (16) | Decoded byte address of the operand |
| dec_byte | input | 1 | Operand is a single byte |
| alu_op | output | 4 | ALU function, low bits of the operation code |
| alu_a | output | 16 | First source value |
| alu_b | output | 16 | Second source value |
| alu_y | input | 16 | ALU result (combinational) |

## Verification
The hardest condition to reach from the ports is an instruction that overwrites the counter location. The redirect only shows if the next fetch takes the new value and not the incremented one. The bench places a copy instruction whose destination is the counter and whose source holds a far address. At the fall-through address it puts a fire code, and at the far address a real program. The run proves the redirect only if it ends in a normal halt with the far program's results in memory. A monitor on the memory port also confirms that no register read happens before the counter write-back.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RPC_H, ST_RPC_L, ST_FETCH, ST_WPC_H, ST_WPC_L,
    ST_SRC_H, ST_SRC_L, ST_SRC_E, ST_EXEC, ST_WR_H, ST_WR_L,
    ST_HALT, ST_FIRE
  } fes_state_e;

  localparam logic [7:0] OPC_HALT    = 8'hF0;
  localparam logic [7:0] OPC_FIRE    = 8'hF1;
  localparam logic [7:0] OPC_ALU_MAX = 8'h0C;
endpackage

// File: rtl/fes_word_capture.sv
module fes_word_capture #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_hi,
  input  logic          load_lo,
  input  logic          load_sx,
  input  logic [BW-1:0] din,
  output logic [2*BW-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
    end else if (load_sx) begin
      word <= {{BW{din[BW-1]}}, din};
    end else begin
      if (load_hi) word[2*BW-1:BW] <= din;
      if (load_lo) word[BW-1:0]    <= din;
    end
  end
endmodule

// File: rtl/fes_ibuf.sv
module fes_ibuf #(
  parameter int BW    = 8,
  parameter int NBYTE = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(NBYTE)-1:0] wr_idx,
  input  logic [BW-1:0]            din,
  output logic [NBYTE-1:0][BW-1:0] bytes
);
  for (genvar g = 0; g < NBYTE; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) bytes[g] <= '0;
      else if (wr_en && wr_idx == g) bytes[g] <= din;
    end
  end
endmodule

// File: rtl/fes_sequencer.sv
module fes_sequencer #(
  parameter int AW = 16,
  parameter logic [AW-1:0] PC_LOC = 16'h0016
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          halted,
  output logic          fire,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic [7:0]    dec_operand,
  input  logic [AW-1:0] dec_addr,
  input  logic          dec_byte,
  output logic [3:0]    alu_op,
  output logic [15:0]   alu_a,
  output logic [15:0]   alu_b,
  input  logic [15:0]   alu_y
);
  import fes_pkg::*;

  localparam int BW     = 8;
  localparam int WW     = 2 * BW;
  localparam int NBYTE  = 4;
  localparam int IW     = $clog2(NBYTE);
  localparam int NSRC   = 2;

  fes_state_e state, state_n;
  logic [IW-1:0] cnt;
  logic          sel;
  logic          src_is_byte;
  logic [BW-1:0] pc_hi;
  logic [AW-1:0] pc;
  logic [WW-1:0] res;
  logic [AW-1:0] npc;
  logic [AW-1:0] fetch_addr;
  logic [NBYTE-1:0][BW-1:0] ib;
  logic [NSRC-1:0][WW-1:0]  src;
  logic ib_wr;
  logic [IW-1:0] ib_idx;

  assign npc = pc + AW'(NBYTE);
  assign fetch_addr = (cnt == '0) ? AW'({pc_hi, mem_rdata}) : pc + AW'(cnt);

  // instruction byte capture: byte k arrives one cycle after its request
  assign ib_wr  = (state == ST_FETCH && cnt != '0) || state == ST_WPC_H;
  assign ib_idx = (state == ST_WPC_H) ? IW'(NBYTE - 1) : IW'(cnt - 1'b1);

  fes_ibuf #(.BW(BW), .NBYTE(NBYTE)) u_ibuf (
    .clk(clk), .rst_n(rst_n), .wr_en(ib_wr), .wr_idx(ib_idx),
    .din(mem_rdata), .bytes(ib)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    fes_word_capture #(.BW(BW)) u_cap (
      .clk(clk), .rst_n(rst_n),
      .load_hi(state == ST_SRC_L && sel == g),
      .load_lo(state == ST_SRC_E && sel == g && !src_is_byte),
      .load_sx(state == ST_SRC_E && sel == g && src_is_byte),
      .din(mem_rdata), .word(src[g])
    );
  end

  assign alu_op = ib[0][3:0];
  assign alu_a  = src[0];
  assign alu_b  = src[1];

  always_comb begin
    dec_operand = ib[1];
    if (state == ST_SRC_H || state == ST_SRC_L || state == ST_SRC_E)
      dec_operand = sel ? ib[3] : ib[2];
  end

  // memory request generation
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_RPC_H: begin mem_req = 1'b1; mem_addr = PC_LOC; end
      ST_RPC_L: begin mem_req = 1'b1; mem_addr = PC_LOC + 1'b1; end
      ST_FETCH: begin mem_req = 1'b1; mem_addr = fetch_addr; end
      ST_WPC_H: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = PC_LOC; mem_wdata = npc[AW-1:AW-BW];
      end
      ST_WPC_L: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = PC_LOC + 1'b1; mem_wdata = npc[BW-1:0];
      end
      ST_SRC_H: begin mem_req = 1'b1; mem_addr = dec_addr; end
      ST_SRC_L: begin mem_req = 1'b1; mem_addr = dec_addr + 1'b1; end
      ST_WR_H: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = dec_addr;
        mem_wdata = dec_byte ? res[BW-1:0] : res[WW-1:BW];
      end
      ST_WR_L: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = dec_addr + 1'b1; mem_wdata = res[BW-1:0];
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE, ST_HALT, ST_FIRE: if (start) state_n = ST_RPC_H;
      ST_RPC_H: state_n = ST_RPC_L;
      ST_RPC_L: state_n = ST_FETCH;
      ST_FETCH: if (cnt == IW'(NBYTE - 1)) state_n = ST_WPC_H;
      ST_WPC_H: state_n = ST_WPC_L;
      ST_WPC_L: begin
        if (ib[0] == OPC_HALT)          state_n = ST_HALT;
        else if (ib[0] == OPC_FIRE)     state_n = ST_FIRE;
        else if (ib[0] <= OPC_ALU_MAX)  state_n = ST_SRC_H;
        else                            state_n = ST_RPC_H;
      end
      ST_SRC_H: state_n = dec_byte ? ST_SRC_E : ST_SRC_L;
      ST_SRC_L: state_n = ST_SRC_E;
      ST_SRC_E: state_n = sel ? ST_EXEC : ST_SRC_H;
      ST_EXEC:  state_n = ST_WR_H;
      ST_WR_H:  state_n = dec_byte ? ST_RPC_H : ST_WR_L;
      ST_WR_L:  state_n = ST_RPC_H;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      sel         <= 1'b0;
      src_is_byte <= 1'b0;
      pc_hi       <= '0;
      pc          <= '0;
      res         <= '0;
    end else begin
      state <= state_n;
      if (state == ST_RPC_L) pc_hi <= mem_rdata;
      if (state == ST_FETCH) begin
        cnt <= cnt + 1'b1;
        if (cnt == '0) pc <= fetch_addr;
      end else begin
        cnt <= '0;
      end
      if (state == ST_WPC_L) sel <= 1'b0;
      if (state == ST_SRC_E) sel <= 1'b1;
      if (state == ST_SRC_H) src_is_byte <= dec_byte;
      if (state == ST_EXEC)  res <= alu_y;
    end
  end

  assign busy   = !(state == ST_IDLE || state == ST_HALT || state == ST_FIRE);
  assign halted = (state == ST_HALT);
  assign fire   = (state == ST_FIRE);
endmodule

// File: rtl/fes_sequencer_chk.sv
module fes_sequencer_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] PC_LOC = 16'h0016
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          halted,
  input logic          fire,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_pc_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_req && !mem_we && mem_addr == PC_LOC));

  p_we_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  p_halt_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!busy && !fire));

  p_fire_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (!busy && !halted));
endmodule

bind fes_sequencer fes_sequencer_chk #(.AW(AW), .PC_LOC(PC_LOC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .halted(halted), .fire(fire),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/fes_sequencer_test.sv
module fes_sequencer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, halted, fire, mem_req, mem_we, dec_byte;
  logic [15:0] mem_addr, dec_addr, alu_a, alu_b, alu_y;
  logic [7:0]  mem_wdata, dec_operand;
  logic [7:0]  mem_rdata = 8'h00;
  logic [3:0]  alu_op;
  logic [7:0]  mem [0:1023];
  int n_chk = 0;
  int n_bad = 0;
  logic pc_wr_seen, order_err;

  always #5 clk = ~clk;

  fes_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .halted(halted),
    .fire(fire), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dec_operand(dec_operand),
    .dec_addr(dec_addr), .dec_byte(dec_byte), .alu_op(alu_op), .alu_a(alu_a),
    .alu_b(alu_b), .alu_y(alu_y)
  );

  // memory model: one byte per cycle, read data one cycle later (R10)
  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:0]];
  end

  // decoder model: bit 6 selects byte location, bits 5:0 the address
  assign dec_addr = {10'd0, dec_operand[5:0]};
  assign dec_byte = dec_operand[6];

  always_comb begin
    case (alu_op)
      4'd0:  alu_y = alu_a + alu_b;
      4'd1:  alu_y = alu_a - alu_b;
      4'd5:  alu_y = alu_a & alu_b;
      4'd6:  alu_y = alu_a | alu_b;
      4'd7:  alu_y = alu_a ^ alu_b;
      4'd10: alu_y = alu_a + 16'd1;
      4'd11: alu_y = alu_a - 16'd1;
      4'd12: alu_y = alu_a;
      default: alu_y = 16'h0000;
    endcase
  end

  // order monitor for R3: no register read before the counter write-back
  always @(posedge clk) begin
    if (mem_req && mem_we && mem_addr == 16'h0017) pc_wr_seen <= 1'b1;
    if (mem_req && !mem_we && mem_addr < 16'h0016 && !pc_wr_seen) order_err <= 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int k = 0; k < 1024; k++) mem[k] = 8'h00;
  endtask

  task automatic put_word(input int a, input logic [15:0] v);
    mem[a] = v[15:8];
    mem[a + 1] = v[7:0];
  endtask

  function automatic logic [15:0] get_word(input int a);
    return {mem[a], mem[a + 1]};
  endfunction

  task automatic put_instr(input int a, input logic [7:0] o, input logic [7:0] d,
                           input logic [7:0] s1, input logic [7:0] s2);
    mem[a] = o; mem[a + 1] = d; mem[a + 2] = s1; mem[a + 3] = s2;
  endtask

  task automatic run_prog();
    @(negedge clk);
    pc_wr_seen = 1'b0;
    order_err = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", 32'(busy), 32'd1);
    for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
    if (busy) check("watchdog", 32'd1, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 halted", 32'(halted), 32'd0);
    check("R1 fire", 32'(fire), 32'd0);
    check("R1 mem_req", 32'(mem_req), 32'd0);
  endtask

  task automatic t_words();
    clear_mem();
    put_word(16'h16, 16'h0100);
    put_word(16'h02, 16'h1234);
    put_word(16'h04, 16'h2345);
    put_word(16'h0A, 16'h4131);
    put_word(16'h0C, 16'h2121);
    put_instr(16'h100, 8'h00, 8'h00, 8'h02, 8'h04); // add a,b,c
    put_instr(16'h104, 8'h01, 8'h06, 8'h0A, 8'h0C); // sub d,y,i
    put_instr(16'h108, 8'h07, 8'h08, 8'h02, 8'h04); // xor x,b,c
    put_instr(16'h10C, 8'hF0, 8'h00, 8'h00, 8'h00);
    run_prog();
    check("R4 add word", 32'(get_word(16'h00)), 32'h3579);
    check("R4 sub word", 32'(get_word(16'h06)), 32'h2010);
    check("R10 xor word", 32'(get_word(16'h08)), 32'h3171);
    check("R3 counter written back", 32'(get_word(16'h16)), 32'h0110);
    check("R3 write-back before operand read", 32'(order_err), 32'd0);
    check("R6 halted", 32'(halted), 32'd1);
    check("R6 fire low", 32'(fire), 32'd0);
    @(negedge clk);
    check("R6 no request after halt", 32'(mem_req), 32'd0);
  endtask

  task automatic t_bytes();
    clear_mem();
    put_word(16'h16, 16'h0100);
    put_word(16'h00, 16'h0010);
    put_word(16'h02, 16'hAAAA);
    put_word(16'h04, 16'h1FF1);
    put_word(16'h06, 16'h1234);
    put_word(16'h08, 16'h0001);
    put_instr(16'h100, 8'h00, 8'h00, 8'h00, 8'h45); // add a,a,c.lo (0xF1 -> 0xFFF1)
    put_instr(16'h104, 8'h00, 8'h43, 8'h06, 8'h08); // add b.lo,d,x
    put_instr(16'h108, 8'h0C, 8'h0A, 8'h44, 8'h00); // mov y,c.hi (0x1F)
    put_instr(16'h10C, 8'hF0, 8'h00, 8'h00, 8'h00);
    run_prog();
    check("R5 sign-extended byte source", 32'(get_word(16'h00)), 32'h0001);
    check("R5 byte destination", 32'(get_word(16'h02)), 32'hAA35);
    check("R5 positive byte source", 32'(get_word(16'h0A)), 32'h001F);
  endtask

  task automatic t_undefined();
    clear_mem();
    put_word(16'h16, 16'h0100);
    put_word(16'h00, 16'h5555);
    put_word(16'h02, 16'h0101);
    put_instr(16'h100, 8'h0D, 8'h00, 8'h02, 8'h02);
    put_instr(16'h104, 8'hF7, 8'h00, 8'h02, 8'h02);
    put_instr(16'h108, 8'h0A, 8'h02, 8'h02, 8'h00); // add1 b,b
    put_instr(16'h10C, 8'hF0, 8'h00, 8'h00, 8'h00);
    run_prog();
    check("R8 undefined writes nothing", 32'(get_word(16'h00)), 32'h5555);
    check("R8 execution continues", 32'(get_word(16'h02)), 32'h0102);
    check("R8 halted after nops", 32'(halted), 32'd1);
  endtask

  task automatic t_fire();
    clear_mem();
    put_word(16'h16, 16'h0100);
    put_instr(16'h100, 8'hF1, 8'h00, 8'h00, 8'h00);
    run_prog();
    check("R7 fire flag", 32'(fire), 32'd1);
    check("R7 not halted", 32'(halted), 32'd0);
    check("R7 busy low", 32'(busy), 32'd0);
  endtask

  task automatic t_redirect();
    clear_mem();
    put_word(16'h16, 16'h0100);
    put_word(16'h08, 16'h0200);
    put_word(16'h02, 16'h0003);
    put_word(16'h04, 16'h0004);
    put_instr(16'h100, 8'h0C, 8'h16, 8'h08, 8'h00); // mov pc,x
    put_instr(16'h104, 8'hF1, 8'h00, 8'h00, 8'h00);
    put_instr(16'h200, 8'h00, 8'h00, 8'h02, 8'h04);
    put_instr(16'h204, 8'hF0, 8'h00, 8'h00, 8'h00);
    run_prog();
    check("R9 redirect avoided fall-through", 32'(fire), 32'd0);
    check("R9 redirected program ran", 32'(get_word(16'h00)), 32'h0007);
    check("R9 counter after redirect", 32'(get_word(16'h16)), 32'h0208);
  endtask

  initial begin
    pc_wr_seen = 1'b0;
    order_err = 1'b0;
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_words();
    t_bytes();
    t_undefined();
    t_fire();
    t_redirect();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule